// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two signed integers of equal, even width and returns the exact product at twice that width. The multiplier operand is recoded in radix 4. Each group of three overlapping bits selects one multiple of the multiplicand from the set {0, +A, +2A, -A, -2A}. This halves the number of partial-product rows to WIDTH/2. Row i is placed at weight 4^i.

Each row keeps only one inverted sign bit plus a constant 1 directly above it, so no sign bits are replicated. A single extra 1 at weight 2^WIDTH completes the correction. Negative multiples are formed by bitwise inversion, and a 1 is added at the row's least significant position. All rows and the correction word are summed modulo 2^(2·WIDTH).

The product can be used combinationally, or registered once with an asynchronous active-low reset. The register is selected by a parameter and is present by default.

Top module: `booth_mul`

## Requirements
- R1: For every pair of WIDTH-bit two's-complement operands, `prod_o` equals the exact signed product as a 2·WIDTH-bit two's-complement value.
- R2: With OUT_REG = 1, a new operand pair shows on `prod_o` one rising clock edge after it is applied. The output keeps the previous product until that edge.
- R3: While `rst_ni` is low, `prod_o` reads zero. This holds both when reset is applied before any clock and when it is asserted while a nonzero product is showing.
- R4: Recoding uses the triplet {b[2i+1], b[2i], b[2i-1]}, with b[-1] = 0. The codes 000 and 111 select 0; 001 and 010 select +A; 011 selects +2A; 100 selects -2A; 101 and 110 select -A. Small positive multipliers (1 to 7), which exercise each code in the low rows, give exact products.
- R5: If either operand is zero, the product is zero.
- R6: Extreme pairs give exact results with no overflow: -2^(WIDTH-1) squared gives +2^(2·WIDTH-2), and products involving 2^(WIDTH-1)-1 are exact.
- R7: A multiplier of all ones (-1) gives the two's-complement negation of the multiplicand, sign-extended to 2·WIDTH bits. This holds even for the most negative multiplicand.
- R8: When both operands are nonzero, the product's top bit equals the XOR of the operands' sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | WIDTH | Multiplicand, two's complement |
| b_i | input | WIDTH | Multiplier, two's complement, radix-4 recoded |
| prod_o | output | 2·WIDTH | Signed product |

## Verification
The bench builds the block with WIDTH = 8 and OUT_REG = 1. At that width the whole operand space of 65,536 pairs can be swept back to back in one run. Every triplet code therefore occurs in every row position, and every sign-correction carry pattern occurs as well, including the carries that spill past the top bit and must be dropped. The registered variant also brings the one-edge latency and the asynchronous clearing of the output within reach of direct checks.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
    // Control word for one recoded digit: sign, single multiple, double multiple
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } digit_ctrl_t;
endpackage

// File: rtl/booth_mul_enc.sv
module booth_mul_enc
    import booth_mul_pkg::*;
(
    input  logic [2:0]  trip_i,
    output digit_ctrl_t ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        unique case (trip_i)
            3'b001, 3'b010: ctrl_o.one = 1'b1;
            3'b011:         ctrl_o.two = 1'b1;
            3'b100:         begin ctrl_o.two = 1'b1; ctrl_o.neg = 1'b1; end
            3'b101, 3'b110: begin ctrl_o.one = 1'b1; ctrl_o.neg = 1'b1; end
            default:        ctrl_o = '0;
        endcase
    end

    // R4: at most one magnitude is chosen, and a negative digit always has a magnitude
    always_comb begin
        if (!$isunknown(trip_i)) begin
            p_sel_onehot_r4: assert ($onehot0({ctrl_o.one, ctrl_o.two}));
            p_neg_needs_mag_r4: assert (!ctrl_o.neg || ctrl_o.one || ctrl_o.two);
        end
    end
endmodule

// File: rtl/booth_mul_row.sv
module booth_mul_row
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX   = 0
) (
    input  logic [WIDTH-1:0]   a_i,
    input  digit_ctrl_t        ctrl_i,
    output logic [2*WIDTH-1:0] row_o
);
    localparam int SEL_W = WIDTH + 1;
    localparam int SHIFT = 2 * IDX;
    localparam int KPOS  = WIDTH + SHIFT + 1;

    logic [SEL_W-1:0]   mag;
    logic [SEL_W-1:0]   sel;
    logic [2*WIDTH-1:0] body;

    always_comb begin
        if (ctrl_i.one)      mag = {a_i[WIDTH-1], a_i};
        else if (ctrl_i.two) mag = {a_i, 1'b0};
        else                 mag = '0;
        sel  = mag ^ {SEL_W{ctrl_i.neg}};
        body = {{(WIDTH-1){1'b0}}, ~sel[WIDTH], sel[WIDTH-1:0]} << SHIFT;
        row_o = body;
        row_o[KPOS] = 1'b1;
    end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_mul_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [2*WIDTH-1:0] prod_o
);
    localparam int ROWS  = WIDTH / 2;
    localparam int PW    = 2 * WIDTH;

    typedef struct packed {
        logic [PW-1:0] prod;
    } state_t;

    state_t state_d, state_q;

    logic [WIDTH:0]    b_ext;
    digit_ctrl_t       ctrl [ROWS];
    logic [PW-1:0]     rows [ROWS];
    logic [PW-1:0]     corr;

    assign b_ext = {b_i, 1'b0};

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        booth_mul_enc u_enc (
            .trip_i (b_ext[2*i +: 3]),
            .ctrl_o (ctrl[i])
        );
        booth_mul_row #(.WIDTH(WIDTH), .IDX(i)) u_row (
            .a_i    (a_i),
            .ctrl_i (ctrl[i]),
            .row_o  (rows[i])
        );
    end

    // Row LSB increments for negative digits and the single 2^WIDTH constant
    always_comb begin
        corr = '0;
        corr[WIDTH] = 1'b1;
        for (int i = 0; i < ROWS; i++) begin
            corr[2*i] = ctrl[i].neg;
        end
    end

    always_comb begin
        logic [PW-1:0] acc;
        acc = corr;
        for (int i = 0; i < ROWS; i++) begin
            acc = acc + rows[i];
        end
        state_d.prod = acc;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) state_q <= '0;
            else         state_q <= state_d;
        end
    end else begin : g_comb
        assign state_q = state_d;
    end

    assign prod_o = state_q.prod;

    // R5 and R8: zero absorbs, sign follows the operand signs
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            p_zero_a_r5: assert (a_i != '0 || state_d.prod == '0);
            p_zero_b_r5: assert (b_i != '0 || state_d.prod == '0);
            p_sign_r8: assert (a_i == '0 || b_i == '0 ||
                               state_d.prod[PW-1] == (a_i[WIDTH-1] ^ b_i[WIDTH-1]));
        end
    end
endmodule

// File: tb/booth_mul_test.sv
module booth_mul_test;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic [PW-1:0] prod;

    always #4 clk = ~clk;

    booth_mul #(.WIDTH(W), .OUT_REG(1'b1)) uut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .a_i    (a),
        .b_i    (b),
        .prod_o (prod)
    );

    typedef struct {
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [PW-1:0] exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    mon_on = 1'b0;

    function automatic logic [PW-1:0] model(logic [W-1:0] x, logic [W-1:0] y);
        int p;
        p = int'($signed(x)) * int'($signed(y));
        return p[PW-1:0];
    endfunction

    function automatic string tag_of(logic [W-1:0] x, logic [W-1:0] y);
        logic [W-1:0] mn, mx;
        mn = {1'b1, {(W-1){1'b0}}};
        mx = {1'b0, {(W-1){1'b1}}};
        if (x == '0 || y == '0)                                 return "R5";
        if ((x == mn || x == mx) && (y == mn || y == mx))       return "R6";
        if (y == '1)                                            return "R7";
        if (y < 8)                                              return "R4";
        if (x[W-1] ^ y[W-1])                                    return "R8";
        return "R1";
    endfunction

    task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp,
                         logic [W-1:0] x, logic [W-1:0] y);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, x, y, act, exp);
        end
    endtask

    task automatic push(logic [W-1:0] x, logic [W-1:0] y);
        item_t it;
        @(negedge clk);
        a = x;
        b = y;
        it.a = x;
        it.b = y;
        it.exp = model(x, y);
        q.push_back(it);
    endtask

    // Monitor: a pair driven at a falling edge is visible just after the next rising edge (R2)
    always @(posedge clk) begin
        if (mon_on) begin
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(tag_of(it.a, it.b), prod, it.exp, it.a, it.b);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [PW-1:0] old;
        #1 rst_n = 1'b0;
        a = 8'h07;
        b = 8'h09;
        repeat (3) @(posedge clk);
        #1 check("R3", prod, '0, a, b);

        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                push(W'(i), W'(j));
            end
        end
        repeat (3) @(posedge clk);
        mon_on = 1'b0;
        #2;

        // R2: the output holds until the next rising edge, then updates
        @(negedge clk);
        a = 8'h05;
        b = 8'hFD;
        old = model(8'hFF, 8'hFF);
        #1 check("R2", prod, old, a, b);
        @(posedge clk);
        #1 check("R2", prod, model(8'h05, 8'hFD), a, b);

        // R6 directed: most negative squared
        @(negedge clk);
        a = 8'h80;
        b = 8'h80;
        @(posedge clk);
        #1 check("R6", prod, 16'h4000, a, b);

        // R3: asynchronous clear while a nonzero product is showing
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R3", prod, '0, a, b);
        @(posedge clk);
        #1 check("R3", prod, '0, a, b);

        finish_run();
    end
endmodule